// File: doc/BRIEF.md
# Configuration change notification queue

This block sits between a serial line multiplexer's processor-facing registers and a host-side backend. It keeps one transmit-direction queue that the backend drains through a single read port. That queue carries two kinds of word: characters the processor sends on a line, and flagged notification words that tell the backend the multiplexer's configuration has changed. A notification is raised when the processor writes a new value into the status register. One is also raised when it switches the receiver of any line on or off. A second queue runs the other way. Into it the backend injects received characters, each tagged with its line number, and the processor reads them out.

Each queue word is 14 bits wide and has five fields. Bit 13 is a valid flag and bit 12 is a last flag. Bit 11 is a notification flag, bits 10:8 hold a line number or a notification subtype, and bits 7:0 hold data. A word becomes visible on the read port at the clock edge that samples the read strobe. It stays there until the next read. Both queues report their fill level on separate outputs. Three sources can feed the transmit queue in the same cycle. They are queued in a fixed priority order, and words that find no free slot are dropped.

Top module: `cq_notify_queue`

## Requirements
- R1: A read-port word has the layout valid = bit 13, last = bit 12, notification = bit 11, line or subtype = bits 10:8, data = bits 7:0.
- R2: A status write whose value differs from the held status queues one word with notification = 1, subtype 3'd1 and the new value as data. A write of the held value queues nothing. In both cases `cfg_state` shows the written value one cycle later.
- R3: A receiver-on write that changes the bit of its line queues one word with notification = 1, subtype 3'd2 and data equal to the whole 8-bit mask after the change. A write that leaves the bit as it was queues nothing. Switching on lines 5, 3 and 1 from an empty mask gives masks 8'o040, 8'o050 and 8'o052.
- R4: A transmitted character is queued with notification = 0, its line number in bits 10:8 and the character in bits 7:0.
- R5: When a status change, a receiver-on change and a character occur in the same cycle, all three are queued in the order status, receiver-on, character.
- R6: Words leave each queue in the order they entered. Each is presented with valid = 1 at the edge that samples the read strobe and is held until the next read.
- R7: A read of an empty queue presents an all-zero word (valid = 0) and leaves the fill level at zero.
- R8: The last flag is 1 exactly when the word read was the only entry in its queue at the time of the read.
- R9: `tx_fill` and `rx_fill` report each queue's entry count separately. Four notifications plus 18 characters give a transmit count of 22.
- R10: A backend injection queues its line and data byte on the receive side. The processor reads it with notification = 0.
- R11: A queue never holds more than its depth. Same-cycle words are admitted in priority order while space remains, and the rest are dropped.
- R12: After reset both fills, the status value, the receiver-on mask and both read words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Processor writes the status register |
| cfg_wdata | input | 8 | Value written to the status register |
| cfg_state | output | 8 | Held status value |
| rxon_wr | input | 1 | Processor sets one line's receiver-on bit |
| rxon_line | input | 3 | Line addressed by the receiver-on write |
| rxon_on | input | 1 | New receiver-on value for that line |
| rxon_mask | output | 8 | Current receiver-on mask, one bit per line |
| txc_vld | input | 1 | Processor sends a character |
| txc_line | input | 3 | Line of the sent character |
| txc_data | input | 8 | Sent character |
| host_rd | input | 1 | Backend reads the transmit-direction queue |
| host_word | output | 14 | Word read from the transmit-direction queue |
| inj_wr | input | 1 | Backend injects a received character |
| inj_line | input | 3 | Line of the injected character |
| inj_data | input | 8 | Injected character |
| cpu_rd | input | 1 | Processor reads the receive-direction queue |
| cpu_word | output | 14 | Word read from the receive-direction queue |
| rx_fill | output | $clog2(DEPTH_RX+1) | Receive-direction queue count |
| tx_fill | output | $clog2(DEPTH_TX+1) | Transmit-direction queue count |

## Verification
A status change, a receiver-on change and a sent character can all need a transmit-queue slot in the same cycle. The bench drives all three together in a single cycle and checks that the drained words appear in the order status, receiver-on, character. It repeats this with only one slot free and checks that just the status notification is kept, after which the fill level stays at the depth.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int LINE_W = 3;
    localparam int DATA_W = 8;
    localparam int NLINES = 1 << LINE_W;

    typedef struct packed {
        logic              notif;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } entry_t;

    typedef struct packed {
        logic   valid;
        logic   last;
        entry_t body;
    } word_t;

    localparam int WORD_W = $bits(word_t);

    localparam logic [LINE_W-1:0] NOTE_STATUS = 3'd1;
    localparam logic [LINE_W-1:0] NOTE_RXON   = 3'd2;
endpackage

// File: rtl/cq_cfg_track.sv
module cq_cfg_track
    import cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rxon_wr,
    input  logic [LINE_W-1:0] rxon_line,
    input  logic              rxon_on,
    output logic [DATA_W-1:0] cfg_state,
    output logic [NLINES-1:0] rxon_mask,
    output logic              stat_vld,
    output entry_t            stat_ent,
    output logic              mask_vld,
    output entry_t            mask_ent
);
    logic [NLINES-1:0] nxt_mask;

    always_comb begin
        nxt_mask            = rxon_mask;
        nxt_mask[rxon_line] = rxon_on;
        stat_vld            = cfg_wr && (cfg_wdata != cfg_state);
        stat_ent.notif      = 1'b1;
        stat_ent.line       = NOTE_STATUS;
        stat_ent.data       = cfg_wdata;
        mask_vld            = rxon_wr && (nxt_mask != rxon_mask);
        mask_ent.notif      = 1'b1;
        mask_ent.line       = NOTE_RXON;
        mask_ent.data       = DATA_W'(nxt_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_state <= '0;
            rxon_mask <= '0;
        end else begin
            if (cfg_wr)  cfg_state <= cfg_wdata;
            if (rxon_wr) rxon_mask <= nxt_mask;
        end
    end
endmodule

// File: rtl/cq_fifo.sv
module cq_fifo
    import cq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NWR   = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWR-1:0]             push_vld,
    input  entry_t [NWR-1:0]           push_ent,
    input  logic                       pop,
    output word_t                      rd_word,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam int SW = CW + 2;

    entry_t          mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [NWR-1:0]  acc;
    logic [SW-1:0]   off [NWR];
    logic [SW-1:0]   n_acc;
    logic            pop_ok;

    always_comb begin
        logic [SW-1:0] run;
        run = '0;
        for (int i = 0; i < NWR; i++) begin
            acc[i] = push_vld[i] && ((SW'(fill) + run) < SW'(DEPTH));
            off[i] = run;
            run    = run + SW'(acc[i]);
        end
        n_acc  = run;
        pop_ok = pop && (fill != '0);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NWR; i++) begin
            if (acc[i]) mem[wptr + off[i][AW-1:0]] <= push_ent[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            fill    <= '0;
            rd_word <= '0;
        end else begin
            wptr <= wptr + n_acc[AW-1:0];
            rptr <= rptr + AW'(pop_ok);
            fill <= fill + CW'(n_acc) - CW'(pop_ok);
            if (pop) begin
                if (pop_ok) rd_word <= {1'b1, (fill == CW'(1)), mem[rptr]};
                else        rd_word <= '0;
            end
        end
    end
endmodule

// File: rtl/cq_notify_queue.sv
module cq_notify_queue
    import cq_pkg::*;
#(
    parameter int DEPTH_TX = 32,
    parameter int DEPTH_RX = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [7:0]                    cfg_wdata,
    output logic [7:0]                    cfg_state,
    input  logic                          rxon_wr,
    input  logic [2:0]                    rxon_line,
    input  logic                          rxon_on,
    output logic [7:0]                    rxon_mask,
    input  logic                          txc_vld,
    input  logic [2:0]                    txc_line,
    input  logic [7:0]                    txc_data,
    input  logic                          host_rd,
    output logic [13:0]                   host_word,
    input  logic                          inj_wr,
    input  logic [2:0]                    inj_line,
    input  logic [7:0]                    inj_data,
    input  logic                          cpu_rd,
    output logic [13:0]                   cpu_word,
    output logic [$clog2(DEPTH_RX+1)-1:0] rx_fill,
    output logic [$clog2(DEPTH_TX+1)-1:0] tx_fill
);
    localparam int NSRC = 3;

    logic              stat_vld, mask_vld;
    entry_t            stat_ent, mask_ent, char_ent, inj_ent;
    logic [NSRC-1:0]   tx_vld;
    entry_t [NSRC-1:0] tx_ent;
    word_t             tx_word, rx_word;

    cq_cfg_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .rxon_wr   (rxon_wr),
        .rxon_line (rxon_line),
        .rxon_on   (rxon_on),
        .cfg_state (cfg_state),
        .rxon_mask (rxon_mask),
        .stat_vld  (stat_vld),
        .stat_ent  (stat_ent),
        .mask_vld  (mask_vld),
        .mask_ent  (mask_ent)
    );

    always_comb begin
        char_ent.notif = 1'b0;
        char_ent.line  = txc_line;
        char_ent.data  = txc_data;
        inj_ent.notif  = 1'b0;
        inj_ent.line   = inj_line;
        inj_ent.data   = inj_data;
        // priority order: status, receiver-on, character
        tx_vld         = {txc_vld, mask_vld, stat_vld};
        tx_ent         = {char_ent, mask_ent, stat_ent};
    end

    cq_fifo #(.DEPTH(DEPTH_TX), .NWR(NSRC)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_vld (tx_vld),
        .push_ent (tx_ent),
        .pop      (host_rd),
        .rd_word  (tx_word),
        .fill     (tx_fill)
    );

    cq_fifo #(.DEPTH(DEPTH_RX), .NWR(1)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_vld (inj_wr),
        .push_ent (inj_ent),
        .pop      (cpu_rd),
        .rd_word  (rx_word),
        .fill     (rx_fill)
    );

    assign host_word = tx_word;
    assign cpu_word  = rx_word;
endmodule

// File: rtl/cq_notify_queue_chk.sv
module cq_notify_queue_chk #(
    parameter int DEPTH_TX = 32,
    parameter int DEPTH_RX = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_wr,
    input logic [7:0]                    cfg_wdata,
    input logic [7:0]                    cfg_state,
    input logic                          rxon_wr,
    input logic                          txc_vld,
    input logic                          host_rd,
    input logic [13:0]                   host_word,
    input logic                          inj_wr,
    input logic                          cpu_rd,
    input logic [$clog2(DEPTH_RX+1)-1:0] rx_fill,
    input logic [$clog2(DEPTH_TX+1)-1:0] tx_fill
);
    localparam int TW = $clog2(DEPTH_TX+1);
    localparam int RW = $clog2(DEPTH_RX+1);
    localparam logic [TW-1:0] TX_MAX = TW'(DEPTH_TX);
    localparam logic [RW-1:0] RX_MAX = RW'(DEPTH_RX);

    logic quiet_tx;
    assign quiet_tx = !rxon_wr && !txc_vld && !host_rd;

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && tx_fill == '0 |=> host_word == '0); // R7
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && tx_fill != '0 |=> host_word[13]); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_word)); // R6
    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && tx_fill != '0 |=> host_word[12] == ($past(tx_fill) == TW'(1))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fill <= TX_MAX && rx_fill <= RX_MAX); // R11
    AST_CFG_NOTE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata != cfg_state && quiet_tx && tx_fill < TX_MAX
        |=> tx_fill == $past(tx_fill) + 1'b1); // R2
    AST_CFG_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_wdata == cfg_state && quiet_tx |=> $stable(tx_fill)); // R2
    AST_CFG_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_state == $past(cfg_wdata)); // R2
    AST_INJ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        inj_wr && !cpu_rd && rx_fill < RX_MAX |=> rx_fill == $past(rx_fill) + 1'b1); // R10
endmodule

bind cq_notify_queue cq_notify_queue_chk #(.DEPTH_TX(DEPTH_TX), .DEPTH_RX(DEPTH_RX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_state (cfg_state),
    .rxon_wr   (rxon_wr),
    .txc_vld   (txc_vld),
    .host_rd   (host_rd),
    .host_word (host_word),
    .inj_wr    (inj_wr),
    .cpu_rd    (cpu_rd),
    .rx_fill   (rx_fill),
    .tx_fill   (tx_fill)
);

// File: tb/sim_cq_notify_queue.sv
`timescale 1ns/1ps
module sim_cq_notify_queue;
    localparam int DT = 32;
    localparam int DR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, rxon_wr = 0, rxon_on = 0, txc_vld = 0;
    logic        host_rd = 0, inj_wr = 0, cpu_rd = 0;
    logic [7:0]  cfg_wdata = 0, txc_data = 0, inj_data = 0;
    logic [2:0]  rxon_line = 0, txc_line = 0, inj_line = 0;
    logic [7:0]  cfg_state, rxon_mask;
    logic [13:0] host_word, cpu_word;
    logic [$clog2(DR+1)-1:0] rx_fill;
    logic [$clog2(DT+1)-1:0] tx_fill;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] exp_tx[$];
    logic [11:0] exp_rx[$];
    logic [7:0]  m_stat = 0;
    logic [7:0]  m_mask = 0;

    always #5 clk = ~clk;

    cq_notify_queue #(.DEPTH_TX(DT), .DEPTH_RX(DR)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_tx(input logic [11:0] e);
        if (exp_tx.size() < DT) exp_tx.push_back(e);
    endtask

    // driver: one cycle of processor-side activity, expectations queued in priority order
    task automatic drive(input logic cw, input logic [7:0] cd,
                         input logic rw, input logic [2:0] rl, input logic ro,
                         input logic tv, input logic [2:0] tl, input logic [7:0] td);
        logic [7:0] nm;
        @(negedge clk);
        cfg_wr = cw; cfg_wdata = cd; rxon_wr = rw; rxon_line = rl; rxon_on = ro;
        txc_vld = tv; txc_line = tl; txc_data = td;
        if (cw) begin
            if (cd != m_stat) model_tx({1'b1, 3'd1, cd});
            m_stat = cd;
        end
        if (rw) begin
            nm = m_mask; nm[rl] = ro;
            if (nm != m_mask) model_tx({1'b1, 3'd2, nm});
            m_mask = nm;
        end
        if (tv) model_tx({1'b0, tl, td});
        @(negedge clk);
        cfg_wr = 0; rxon_wr = 0; txc_vld = 0;
    endtask

    // monitor: pop expectation, compare against the word read out
    task automatic host_read(input string req);
        logic [13:0] e;
        @(negedge clk);
        if (exp_tx.size() == 0) e = '0;
        else e = {1'b1, exp_tx.size() == 1, exp_tx.pop_front()};
        host_rd = 1;
        @(negedge clk);
        host_rd = 0;
        check(req, host_word, e);
    endtask

    task automatic inject(input logic [2:0] l, input logic [7:0] d);
        @(negedge clk);
        inj_wr = 1; inj_line = l; inj_data = d;
        if (exp_rx.size() < DR) exp_rx.push_back({1'b0, l, d});
        @(negedge clk);
        inj_wr = 0;
    endtask

    task automatic cpu_read(input string req);
        logic [13:0] e;
        @(negedge clk);
        if (exp_rx.size() == 0) e = '0;
        else e = {1'b1, exp_rx.size() == 1, exp_rx.pop_front()};
        cpu_rd = 1;
        @(negedge clk);
        cpu_rd = 0;
        check(req, cpu_word, e);
    endtask

    task automatic drain(input string req);
        while (exp_tx.size() > 0) host_read(req);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check("R12 tx_fill", tx_fill, 0);
        check("R12 rx_fill", rx_fill, 0);
        check("R12 cfg_state", cfg_state, 0);
        check("R12 rxon_mask", rxon_mask, 0);
        check("R12 host_word", host_word, 0);
        check("R12 cpu_word", cpu_word, 0);

        // R7 empty read
        host_read("R7 empty host read");
        check("R7 fill stays zero", tx_fill, 0);

        // R2 R3 R4 R9: startup notifications then 18 characters
        drive(1, 8'h20, 0, 0, 0, 0, 0, 0);
        check("R2 state follows write", cfg_state, 8'h20);
        drive(0, 0, 1, 3'd5, 1, 0, 0, 0);
        check("R3 mask after line 5", rxon_mask, 8'o040);
        drive(0, 0, 1, 3'd3, 1, 0, 0, 0);
        check("R3 mask after line 3", rxon_mask, 8'o050);
        drive(0, 0, 1, 3'd1, 1, 0, 0, 0);
        check("R3 mask after line 1", rxon_mask, 8'o052);
        for (int k = 1; k <= 6; k++) begin
            drive(0, 0, 0, 0, 0, 1, 3'd1, 8'h10 + 8'(k));
            drive(0, 0, 0, 0, 0, 1, 3'd3, 8'h30 + 8'(k));
            drive(0, 0, 0, 0, 0, 1, 3'd5, 8'h50 + 8'(k));
        end
        check("R9 tx count 22", tx_fill, 22);
        check("R9 rx count 0", rx_fill, 0);
        drain("R1 R4 R6 R8 ordered words");
        host_read("R7 read after drain");

        // R2 same value: nothing queued
        drive(1, 8'h20, 0, 0, 0, 0, 0, 0);
        check("R2 same value no word", tx_fill, 0);
        // R3 unchanged bit: nothing queued; switch-off queues new mask
        drive(0, 0, 1, 3'd5, 1, 0, 0, 0);
        check("R3 unchanged bit no word", tx_fill, 0);
        drive(0, 0, 1, 3'd3, 0, 0, 0, 0);
        check("R3 switch off count", tx_fill, 1);
        drain("R3 switch off word");

        // R5 three sources in one cycle
        drive(1, 8'h81, 1, 3'd0, 1, 1, 3'd7, 8'h5A);
        check("R5 three words queued", tx_fill, 3);
        drain("R5 order status rxon char");

        // R10 receive side
        inject(3'd2, 8'hC3);
        inject(3'd6, 8'h07);
        inject(3'd4, 8'hEE);
        check("R10 rx count", rx_fill, 3);
        check("R10 tx untouched", tx_fill, 0);
        for (int k = 0; k < 3; k++) cpu_read("R10 injected word");
        cpu_read("R7 empty cpu read");

        // R11 overflow: one slot left, three candidates
        for (int k = 0; k < DT - 1; k++) drive(0, 0, 0, 0, 0, 1, 3'(k), 8'(k));
        drive(1, 8'h44, 1, 3'd6, 1, 1, 3'd2, 8'hAB);
        check("R11 fill saturates", tx_fill, DT);
        drive(0, 0, 0, 0, 0, 1, 3'd1, 8'h99);
        check("R11 full drops char", tx_fill, DT);
        drain("R11 kept words");
        check("R11 empty after drain", tx_fill, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule